// File: doc/BRIEF.md
# GPIO Interrupt Detect and Mask Unit

This block watches the 32 synchronised input pins of one GPIO bank and turns pin activity into a single bank interrupt. Each pin is configured on its own to respond to a level or to an edge. It can look for a high level, a low level, a rising edge, a falling edge, or both edges. Every detected event is caught in a sticky status bit, which software clears by writing a one to it.

A mask decides which caught events may drive the interrupt line. Software cannot write the mask directly. It sets mask bits through one write-only register and clears them through another. Detection and latching go on while a pin is masked. A pending event therefore raises the interrupt as soon as its pin is unmasked.

The block sits on the same simple register bus as the bank controller. Writes happen on a clock edge. Reads are combinational from a separate read address.

Top module: `gpio_irq_unit`

## Requirements
- R1: Reset (rst_ni low) clears the trigger-type, polarity, both-edge and status registers to 0 and sets every mask bit to 1; irq_o is then 0.
- R2: A pin with trigger bit 1 (edge; register select 0), polarity bit 1 (select 1) and both-edge bit 0 (select 2) sets its status bit on a 0-to-1 change and not on a 1-to-0 change.
- R3: An edge pin with polarity bit 0 sets its status bit on a 1-to-0 change only.
- R4: An edge pin with both-edge bit 1 sets its status bit on either change, whatever its polarity bit.
- R5: A pin with trigger bit 0 (level) sets its status bit in every cycle its input equals its polarity bit, so a clear written while that level persists leaves the bit set.
- R6: Writing the status register (select 6) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R7: Writing the unmask register (select 4) clears each mask bit written as 1; writing the mask-set register (select 5) sets each mask bit written as 1; bits written as 0 keep their value; the mask reads at select 3.
- R8: irq_o is high exactly when some status bit is 1 and its mask bit is 0; events on masked pins are still latched, and irq_o rises in the cycle after the unmask write.
- R9: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends set.
- R10: The both-edge bit has no effect on a level pin.
- R11: A write to the mask read address (select 3) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Synchronised pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register select |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read register select |
| rd_data_o | output | 32 | Read data (combinational; write-only selects read 0) |
| irq_o | output | 1 | Bank interrupt |

## Verification
Say a pin changes before clock edge k. Its status bit is set at edge k and can be read in the low phase that follows. A register write presented before edge k takes effect at that edge. irq_o follows the mask and status registers with no further delay. The bench gives every stimulus exactly one edge and then reads. The scoreboard monitor compares each expected value on the falling edge of that same cycle, never sooner and never later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TRIG    = 3'd0,
    SEL_POL     = 3'd1,
    SEL_BOTH    = 3'd2,
    SEL_MASK    = 3'd3,
    SEL_UNMASK  = 3'd4,
    SEL_MASKSET = 3'd5,
    SEL_STATUS  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0] wr_data_i,
  output logic [NPINS-1:0] trig_o,
  output logic [NPINS-1:0] pol_o,
  output logic [NPINS-1:0] both_o,
  output logic [NPINS-1:0] mask_o
);
  logic [NPINS-1:0] unmask_w, maskset_w;

  assign unmask_w  = (wr_en_i && wr_addr_i == SEL_UNMASK)  ? wr_data_i : '0;
  assign maskset_w = (wr_en_i && wr_addr_i == SEL_MASKSET) ? wr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o <= '0;
      pol_o  <= '0;
      both_o <= '0;
      mask_o <= '1;
    end else begin
      if (wr_en_i && wr_addr_i == SEL_TRIG) trig_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == SEL_POL)  pol_o  <= wr_data_i;
      if (wr_en_i && wr_addr_i == SEL_BOTH) both_o <= wr_data_i;
      mask_o <= (mask_o & ~unmask_w) | maskset_w;
    end
  end

  AST_MASK_CLEAR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(mask_o) & ~mask_o) & ~$past(unmask_w)) == '0)); // R7

  AST_MASK_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((~$past(mask_o) & mask_o) & ~$past(maskset_w)) == '0)); // R7
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] trig_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] both_i,
  output logic [NPINS-1:0] event_o
);
  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, edge_hit, level_hit;
    assign rise      = pin_i[i] & ~pin_q[i];
    assign fall      = ~pin_i[i] & pin_q[i];
    assign edge_hit  = both_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign level_hit = (pin_i[i] == pol_i[i]);
    assign event_o[i] = trig_i[i] ? edge_hit : level_hit;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | event_i;
  end

  assign irq_o = |(status_o & ~mask_i);

  AST_EVENT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((status_o & $past(event_i)) == $past(event_i))); // R9

  AST_CLEAR_ONLY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_o) & ~status_o) & ~$past(clr_i)) == '0)); // R6

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '1) |-> !irq_o); // R8
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_addr_i,
  output logic [NPINS-1:0] rd_data_o,
  output logic             irq_o
);
  logic [NPINS-1:0] trig, pol, both, mask, events, status, clr;

  gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .trig_o(trig), .pol_o(pol), .both_o(both), .mask_o(mask)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk_i, .rst_ni, .pin_i,
    .trig_i(trig), .pol_i(pol), .both_i(both), .event_o(events)
  );

  assign clr = (wr_en_i && wr_addr_i == SEL_STATUS) ? wr_data_i : '0;

  gpio_irq_status #(.NPINS(NPINS)) u_sts (
    .clk_i, .rst_ni, .event_i(events), .clr_i(clr), .mask_i(mask),
    .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    unique case (rd_addr_i)
      SEL_TRIG:   rd_data_o = trig;
      SEL_POL:    rd_data_o = pol;
      SEL_BOTH:   rd_data_o = both;
      SEL_MASK:   rd_data_o = mask;
      SEL_STATUS: rd_data_o = status;
      default:    rd_data_o = '0;
    endcase
  end

  AST_RESET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mask == '1)); // R1
endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk = 0;
  logic          rst_ni = 0;
  logic [NP-1:0] pin_i = '0;
  logic          wr_en_i = 0;
  logic [2:0]    wr_addr_i = '0;
  logic [NP-1:0] wr_data_i = '0;
  logic [2:0]    rd_addr_i = '0;
  logic [NP-1:0] rd_data_o;
  logic          irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_unit #(.NPINS(NP)) uut (
    .clk_i(clk), .rst_ni, .pin_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .irq_o
  );

  typedef struct {
    logic          is_irq;
    logic [NP-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor: compares each queued expectation on the falling edge
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      logic [NP-1:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {{(NP-1){1'b0}}, irq_o} : rd_data_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_rd(input logic [2:0] sel, input logic [NP-1:0] exp, input string tag);
    item_t it;
    rd_addr_i = sel;
    it.is_irq = 0; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {{(NP-1){1'b0}}, exp}; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  // write applied at the next edge; returns aligned just after that edge
  task automatic wr(input logic [2:0] sel, input logic [NP-1:0] d);
    @(posedge clk); #1;
    wr_en_i = 1; wr_addr_i = sel; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 0;
  endtask

  task automatic pin(input int idx, input logic v);
    @(posedge clk); #1;
    pin_i[idx] = v;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2;
    expect_rd(3'd3, '1, "R1 mask at reset");
    expect_rd(3'd6, '0, "R1 status at reset");
    expect_rd(3'd0, '0, "R1 trig at reset");
    expect_rd(3'd2, '0, "R1 both at reset");
    expect_irq(1'b0, "R1 irq at reset");
    rst_ni = 1;
    step();
    // pin0 rise, pin1 fall, pin2/pin3 both, pin8 level high, pin9 level high+both, rest level high
    wr(3'd0, 32'h0000_000F);
    wr(3'd1, 32'hFFFF_FFF9);
    wr(3'd2, 32'h0000_020C);
    wr(3'd6, '1);
    expect_rd(3'd6, '0, "R6 status cleared by all ones");

    // R2
    pin(0, 1'b1);
    expect_rd(3'd6, 32'h1, "R2 rising edge latched");
    wr(3'd6, 32'hFFFF_FFFE);
    expect_rd(3'd6, 32'h1, "R6 zero bits keep status");
    wr(3'd6, 32'h1);
    pin(0, 1'b0);
    expect_rd(3'd6, 32'h0, "R2 falling edge ignored in rising mode");

    // R3
    pin(1, 1'b1);
    expect_rd(3'd6, 32'h0, "R3 rise ignored in falling mode");
    pin(1, 1'b0);
    expect_rd(3'd6, 32'h2, "R3 falling edge latched");
    wr(3'd6, 32'h2);
    expect_rd(3'd6, 32'h0, "R6 write one clears");

    // R4
    pin(2, 1'b1);
    expect_rd(3'd6, 32'h4, "R4 both-edge rise pol0");
    wr(3'd6, 32'h4);
    pin(2, 1'b0);
    expect_rd(3'd6, 32'h4, "R4 both-edge fall pol0");
    wr(3'd6, 32'h4);
    pin(3, 1'b1);
    expect_rd(3'd6, 32'h8, "R4 both-edge rise pol1");
    wr(3'd6, 32'h8);
    pin(3, 1'b0);
    expect_rd(3'd6, 32'h8, "R4 both-edge fall pol1");
    wr(3'd6, 32'h8);

    // R5 / R10
    pin(8, 1'b1);
    expect_rd(3'd6, 32'h100, "R5 level high latched");
    wr(3'd6, 32'h100);
    expect_rd(3'd6, 32'h100, "R5 clear while level active has no effect");
    pin(9, 1'b1);
    wr(3'd6, 32'h300);
    expect_rd(3'd6, 32'h300, "R10 both-edge bit ignored on level pin");
    pin(8, 1'b0);
    pin(9, 1'b0);
    wr(3'd6, 32'h300);
    expect_rd(3'd6, 32'h0, "R5 status stays clear once level gone");

    // R9: rising edge on pin0 and clear of bit0 in the same cycle
    @(posedge clk); #1;
    pin_i[0] = 1'b1; wr_en_i = 1; wr_addr_i = 3'd6; wr_data_i = 32'h1;
    @(posedge clk); #1;
    wr_en_i = 0;
    expect_rd(3'd6, 32'h1, "R9 event wins over clear");

    // R7 / R8 / R11
    expect_irq(1'b0, "R8 masked pending status keeps irq low");
    wr(3'd4, 32'h1);
    expect_irq(1'b1, "R8 irq rises after unmask");
    expect_rd(3'd3, 32'hFFFF_FFFE, "R7 unmask clears one bit");
    wr(3'd4, 32'h0);
    expect_rd(3'd3, 32'hFFFF_FFFE, "R7 zero write to unmask no change");
    wr(3'd3, 32'h0);
    expect_rd(3'd3, 32'hFFFF_FFFE, "R11 mask address not writable");
    wr(3'd5, 32'h1);
    expect_rd(3'd3, '1, "R7 mask-set sets bit");
    expect_irq(1'b0, "R8 irq low after remask");
    wr(3'd4, 32'h1);
    wr(3'd6, 32'h1);
    expect_irq(1'b0, "R8 irq low with status cleared");
    expect_rd(3'd4, '0, "R7 write-only select reads zero");

    step();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule